// File: doc/BRIEF.md
# Event-Triggered Four-Channel Capture Unit

This block time-stamps events. A 16-bit counter inside the unit runs freely and steps once per clock. Eight global event lines come into the unit. Each line passes through a two-stage synchronizer and then an edge detector. A rotating selector gives each of the four capture channels its own line, and every channel holds one buffer for a captured value.

When a channel sees an edge on its line, the unit stores the counter value in that channel's buffer. In tagged mode, the top bit of the stored value records the direction of the edge instead. Tagged mode is picked by clearing the most significant bit of the period setting. It lets a single input and a single channel measure both the high time and the low time of a waveform.

A host reads one channel at a time through a read strobe. The read frees that channel's buffer. If an event arrives while the buffer still holds a value nobody has read, the event is dropped and the channel reports an error. The event lines are only observed. The unit never drives or consumes them.

Top module: `evcap_unit`

## Requirements
- R1: After reset, the counter is 0, every capture buffer holds 0, and every full flag and every error flag is 0.
- R2: The counter rises by exactly one on each clock edge and wraps modulo 2^16.
- R3: Suppose an event line is sampled with a new level at clock edge k. The capture into the channel that listens to that line happens at edge k+2. The value stored is the counter value held just before edge k+2.
- R4: While `period_msb_i` is 1, a capture stores all 16 counter bits.
- R5: While `period_msb_i` is 0, bit 15 of the stored value is the edge polarity and bits 14:0 are counter bits 14:0. A rising edge gives polarity 1 and a falling edge gives polarity 0.
- R6: `ev_sel_i` is 4 bits wide. Let N be bits 2:0. When bit 3 is 1, channel x listens only to event line (N + x) mod 8.
- R7: While bit 3 of `ev_sel_i` is 0, edges on any line cause no capture. All flags and buffers stay unchanged.
- R8: A capture into an empty buffer sets that channel's full flag.
- R9: If an event reaches a full channel with no read in the same cycle, the event is dropped. The buffer is unchanged and the channel's error flag is set at the next edge.
- R10: A read strobe `rd_en_i` with channel number `rd_ch_i` clears that channel's full and error flags at the next edge. The buffer value is kept, and the other channels are not affected.
- R11: If a read and an event reach the same channel in the same cycle, the new value is stored, the full flag stays 1 and the error flag is 0.
- R12: Edges on lines that no channel listens to have no effect. Several channels may capture on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_msb_i | input | 1 | MSB of the period setting: 1 selects full count, 0 selects polarity tag |
| ev_sel_i | input | 4 | Bit 3 enables events; bits 2:0 give the base line N |
| ev_lines_i | input | 8 | Global event lines, asynchronous |
| rd_en_i | input | 1 | Host read strobe |
| rd_ch_i | input | 2 | Channel addressed by the read |
| count_o | output | 16 | Free-running counter value |
| cap_data_o | output | 64 | Capture buffers; channel x is in bits 16x+15:16x |
| cap_full_o | output | 4 | Per-channel full flag, which is also the capture interrupt flag |
| cap_err_o | output | 4 | Per-channel error flag for a lost capture |

## Verification
The assertions check the following on every cycle:
- The counter steps by one.
- A capture into an empty buffer sets the full flag.
- A capture into a full, unread buffer leaves the data unchanged and raises the error flag.
- A read clears both flags.
- In tagged mode, the stored polarity matches the edge.
- No channel sees an event while the selector is disabled.

Only the bench scenarios can show the routing and the timing end to end. The bench sweeps every base line against every event line and checks which channel captures and at what counter value. It covers both storage modes and both edge directions, the two-cycle synchronizer latency measured at the ports, and simultaneous captures on all channels.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
   localparam int unsigned EVCAP_CNT_W = 16;
   localparam int unsigned EVCAP_NUM_CH = 4;
   localparam int unsigned EVCAP_NUM_EV = 8;

   // one routed event: a detected edge and its direction (1 = rising)
   typedef struct packed {
      logic hit;
      logic pol;
   } evcap_evt_t;
endpackage

// File: rtl/evcap_sync_edge.sv
module evcap_sync_edge #(
   parameter int unsigned NUM_EV = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] lines_i,
   output logic [NUM_EV-1:0] edge_o,
   output logic [NUM_EV-1:0] level_o
);
   initial begin
      stages_min_chk : assert (STAGES >= 2)
         else $error("evcap_sync_edge: at least two sync stages needed");
   end

   logic [NUM_EV-1:0] sync_q [STAGES];
   logic [NUM_EV-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) sync_q[s] <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= lines_i;
         for (int s = 1; s < int'(STAGES); s++) sync_q[s] <= sync_q[s-1];
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign level_o = sync_q[STAGES-1];
   assign edge_o  = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/evcap_route.sv
module evcap_route
   import evcap_pkg::*;
#(
   parameter int unsigned NUM_EV = 8,
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned SEL_W = $clog2(NUM_EV)
) (
   input  logic [SEL_W:0]    sel_i,
   input  logic [NUM_EV-1:0] edge_i,
   input  logic [NUM_EV-1:0] level_i,
   output evcap_evt_t        evt_o [NUM_CH]
);
   initial begin
      ev_pow2_chk : assert (NUM_EV == (1 << SEL_W))
         else $error("evcap_route: line count must be a power of two");
      ch_fit_chk : assert (NUM_CH <= NUM_EV)
         else $error("evcap_route: more channels than lines");
   end

   wire             enable = sel_i[SEL_W];
   wire [SEL_W-1:0] base   = sel_i[SEL_W-1:0];

   for (genvar x = 0; x < int'(NUM_CH); x++) begin : g_ch
      // the index wraps by the natural width of SEL_W bits
      wire [SEL_W-1:0] idx = base + SEL_W'(x);
      assign evt_o[x].hit = enable & edge_i[idx];
      assign evt_o[x].pol = level_i[idx];
   end
endmodule

// File: rtl/evcap_channel.sv
module evcap_channel
   import evcap_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  evcap_evt_t       evt_i,
   input  logic             rd_i,
   input  logic             per_msb_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] data_o,
   output logic             full_o,
   output logic             err_o
);
   initial begin
      cnt_w_chk : assert (CNT_W >= 2)
         else $error("evcap_channel: counter too narrow");
   end

   logic [CNT_W-1:0] stamp;
   logic             take;

   always_comb begin
      stamp = cnt_i;
      if (!per_msb_i) stamp[CNT_W-1] = evt_i.pol;
   end

   assign take = evt_i.hit & (~full_o | rd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         full_o <= 1'b0;
         err_o  <= 1'b0;
      end else if (take) begin
         data_o <= stamp;
         full_o <= 1'b1;
         err_o  <= 1'b0;
      end else if (evt_i.hit) begin
         err_o  <= 1'b1;
      end else if (rd_i) begin
         full_o <= 1'b0;
         err_o  <= 1'b0;
      end
   end

   // R8
   fill_sets_full_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.hit && !full_o) |=> full_o);
   // R9
   drop_keeps_data_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.hit && full_o && !rd_i) |=> (err_o && $stable(data_o)));
   // R10
   read_clears_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !evt_i.hit) |=> (!full_o && !err_o));
   // R5
   pol_tag_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.hit && !full_o && !per_msb_i) |=> (data_o[CNT_W-1] == $past(evt_i.pol)));
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
   import evcap_pkg::*;
#(
   parameter int unsigned CNT_W  = EVCAP_CNT_W,
   parameter int unsigned NUM_CH = EVCAP_NUM_CH,
   parameter int unsigned NUM_EV = EVCAP_NUM_EV,
   localparam int unsigned SEL_W = $clog2(NUM_EV),
   localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    period_msb_i,
   input  logic [SEL_W:0]          ev_sel_i,
   input  logic [NUM_EV-1:0]       ev_lines_i,
   input  logic                    rd_en_i,
   input  logic [CH_W-1:0]         rd_ch_i,
   output logic [CNT_W-1:0]        count_o,
   output logic [NUM_CH*CNT_W-1:0] cap_data_o,
   output logic [NUM_CH-1:0]       cap_full_o,
   output logic [NUM_CH-1:0]       cap_err_o
);
   logic [NUM_EV-1:0] edge_w, level_w;
   evcap_evt_t        evt_w [NUM_CH];
   logic [NUM_CH-1:0] hit_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_o <= '0;
      else        count_o <= count_o + CNT_W'(1);
   end

   evcap_sync_edge #(.NUM_EV(NUM_EV), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .lines_i(ev_lines_i),
      .edge_o(edge_w), .level_o(level_w));

   evcap_route #(.NUM_EV(NUM_EV), .NUM_CH(NUM_CH)) u_route (
      .sel_i(ev_sel_i), .edge_i(edge_w), .level_i(level_w), .evt_o(evt_w));

   for (genvar x = 0; x < int'(NUM_CH); x++) begin : g_chan
      assign hit_w[x] = evt_w[x].hit;
      evcap_channel #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .evt_i(evt_w[x]),
         .rd_i(rd_en_i && (rd_ch_i == CH_W'(x))),
         .per_msb_i(period_msb_i), .cnt_i(count_o),
         .data_o(cap_data_o[x*CNT_W +: CNT_W]),
         .full_o(cap_full_o[x]), .err_o(cap_err_o[x]));
   end

   // R2
   count_step_chk : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count_o == $past(count_o) + CNT_W'(1)));
   // R7
   no_route_when_off_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !ev_sel_i[SEL_W] |-> (hit_w == '0));
endmodule

// File: tb/evcap_unit_bench.sv
`timescale 1ns/1ps
module evcap_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        period_msb_i = 1'b1;
   logic [3:0]  ev_sel_i = '0;
   logic [7:0]  ev_lines_i = '0;
   logic        rd_en_i = 1'b0;
   logic [1:0]  rd_ch_i = '0;
   logic [15:0] count_o;
   logic [63:0] cap_data_o;
   logic [3:0]  cap_full_o, cap_err_o;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   evcap_unit u_evcap_unit (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] slot(input int x);
      return cap_data_o[x*16 +: 16];
   endfunction

   // Toggle the lines in mask; return the stamp count and the new levels.
   // With rd_same set, a read of rd_c is issued in the capture cycle.
   task automatic fire(input logic [7:0] mask, input bit rd_same, input logic [1:0] rd_c,
                       output logic [15:0] cnt, output logic [7:0] lvl);
      @(negedge clk);
      ev_lines_i = ev_lines_i ^ mask;
      lvl = ev_lines_i;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      cnt = count_o;               // value held just before capture edge (R3)
      if (rd_same) begin rd_en_i = 1'b1; rd_ch_i = rd_c; end
      @(posedge clk);
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] c);
      @(negedge clk);
      rd_en_i = 1'b1; rd_ch_i = c;
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   function automatic logic [15:0] expect_val(input logic [15:0] cnt, input logic pol, input logic pm);
      return pm ? cnt : {pol, cnt[14:0]};
   endfunction

   initial begin
      logic [15:0] cnt, c0, old;
      logic [7:0]  lvl;
      repeat (3) @(negedge clk);
      // R1
      check("R1 count", count_o, 0);
      check("R1 data", cap_data_o[31:0], 0);
      check("R1 flags", {cap_full_o, cap_err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk); c0 = count_o;
      @(negedge clk);
      // R2
      check("R2 step", count_o, c0 + 16'd1);

      // R7: disabled selector ignores every line
      ev_sel_i = 4'b0101;
      fire(8'hFF, 0, 0, cnt, lvl);
      check("R7 no capture", {cap_full_o, cap_err_o}, 0);
      check("R7 data", cap_data_o[31:0], 0);

      // R6 R4 R5 R12 R10 R3: sweep base against every line
      for (int n = 0; n < 8; n++) begin
         period_msb_i = n[0];
         ev_sel_i = {1'b1, 3'(n)};
         for (int l = 0; l < 8; l++) begin
            int x;
            x = (l - n + 8) % 8;
            fire(8'(1 << l), 0, 0, cnt, lvl);
            check("R6 R12 channel map", cap_full_o, (x < 4) ? 4'(1 << x) : 4'h0);
            if (x < 4) begin
               check(period_msb_i ? "R3 R4 full stamp" : "R3 R5 tagged stamp",
                     slot(x), expect_val(cnt, lvl[l], period_msb_i));
               do_read(2'(x));
               check("R10 read clears", {cap_full_o, cap_err_o}, 0);
               check("R10 data kept", slot(x), expect_val(cnt, lvl[l], period_msb_i));
            end
         end
      end

      // R12: all channels on one edge
      period_msb_i = 1'b1;
      ev_sel_i = 4'b1011;
      fire(8'hFF, 0, 0, cnt, lvl);
      check("R12 all full", cap_full_o, 4'hF);
      for (int x = 0; x < 4; x++) check("R12 all data", slot(x), cnt);

      // R9: second event on full channel is lost
      old = slot(0);
      fire(8'h08, 0, 0, cnt, lvl);
      check("R9 err set", cap_err_o, 4'h1);
      check("R9 data unchanged", slot(0), old);
      check("R9 still full", cap_full_o, 4'hF);

      // R10: read of ch1 leaves ch0 alone
      do_read(2'd1);
      check("R10 other ch", {cap_full_o, cap_err_o}, {4'hD, 4'h1});
      do_read(2'd0);
      check("R10 err cleared", {cap_full_o, cap_err_o}, {4'hC, 4'h0});

      // R11: read and capture in one cycle on a full channel
      period_msb_i = 1'b0;
      do_read(2'd2);
      fire(8'h08, 0, 0, cnt, lvl);  // ch0 refilled
      fire(8'h08, 1, 2'd0, cnt, lvl);
      check("R11 full kept", cap_full_o[0], 1'b1);
      check("R11 no err", cap_err_o[0], 1'b0);
      check("R11 new data", slot(0), expect_val(cnt, lvl[3], 1'b0));

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule